// File: doc/BRIEF.md
# Frequency Synthesizer Divider and Phase Detector

This block is the digital heart of a frequency-synthesis loop. An oscillator-derived event stream passes through a fixed divide-by-8 prescaler and then a programmable divider with a 15-bit ratio. A crystal-derived event stream is divided by 512 to form the comparison reference. A 4 MHz crystal therefore gives a 7.8125 kHz reference. A phase/frequency detector compares the falling edges of the two divided waves. Its pump-up and pump-down requests have the width of the phase error. A high-impedance flag is raised whenever no request is active.

The core runs on one system clock. Upstream edge detectors present both the oscillator and the crystal as single-cycle tick strobes (`vco_tick`, `xtal_tick`). Software-level control inputs do the following:
- force the pump to high impedance;
- route the two divided waves onto two general-purpose pins for test;
- select the high pump current;
- switch off the filter amplifier.

A new ratio is taken only when the programmable counter wraps, so no period is ever cut short. Ratios below 256 are raised to 256. After reset the active ratio is 256 until the first wrap.

Top module: `synth_pfd_core`

## Requirements
- R1: With a tick on `vco_tick` every cycle, the divided input wave (seen on `port7` in test mode) rises every 8*N cycles, where N is the active ratio.
- R2: Within each divided-input period the wave is high for 8*ceil(N/2) cycles and low for the rest; the falling edge is the compared edge.
- R3: A value on `ratio` becomes active only at the counter wrap (rising edge of the divided input). The period in progress when `ratio` changes completes with the old N, and the next one uses the new N.
- R4: A `ratio` value below 256 is treated as 256. After reset the active ratio is 256 until the first wrap.
- R5: With a tick on `xtal_tick` every cycle, the reference wave (seen on `port6` in test mode) has a period of 512 cycles and is high for 256 of them.
- R6: When the divided input falls d cycles before the reference (d >= 1), `pump_up` is high for exactly d cycles, starting the cycle after the input's falling-edge tick; `pump_dn` stays low.
- R7: When the reference falls d cycles before the divided input, `pump_dn` is high for exactly d cycles; `pump_up` stays low.
- R8: When both falling edges occur in the same cycle, neither `pump_up` nor `pump_dn` goes high, and `pump_hiz` stays 1.
- R9: `pump_hiz` is 1 exactly when neither request is being driven. With `cp_off`=1 the pump is held at high impedance (`pump_hiz`=1, `pump_up`=`pump_dn`=0) whatever the phase.
- R10: With `test_en`=0, `port6`=`port_ctl[0]` and `port7`=`port_ctl[1]`. With `test_en`=1, `port6` carries the reference wave and `port7` the divided input wave.
- R11: `cur_hi` follows `hi_cur` (1 = high pump current), and `amp_en` is the inverse of `amp_off` (1 = filter amplifier enabled).
- R12: `pump_up` and `pump_dn` are never 1 together. Once both detector latches are set, both clear on the next clock.
- R13: After reset: `pump_up`=0, `pump_dn`=0, `pump_hiz`=1, and both divided waves are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_tick | input | 1 | One-cycle strobe per oscillator edge |
| xtal_tick | input | 1 | One-cycle strobe per crystal edge |
| ratio | input | 15 | Programmable divide ratio N |
| cp_off | input | 1 | 1 forces the pump to high impedance |
| test_en | input | 1 | 1 routes the divided waves to the port pins |
| hi_cur | input | 1 | 1 selects the high pump current |
| amp_off | input | 1 | 1 disables the filter amplifier |
| port_ctl | input | 2 | Software levels for the two port pins |
| pump_up | output | 1 | Pump source request |
| pump_dn | output | 1 | Pump sink request |
| pump_hiz | output | 1 | Pump output high impedance |
| cur_hi | output | 1 | Pump current select level |
| amp_en | output | 1 | Filter amplifier enable |
| port6 | output | 1 | Port pin: software level or reference wave |
| port7 | output | 1 | Port pin: software level or divided input wave |

## Verification
The divider is run with an odd ratio (301), a ratio below the floor (100) and an even ratio (520). The ratio is changed shortly after a wrap each time. Period-by-period expected lengths go into a scoreboard, which tells a load at the wrap apart from an immediate load, shows whether the floor is applied, and exposes wrong high/low splits on odd N. The detector is driven from a state just before both falling edges with input-first, reference-first and coincident orderings, and once with the pump forced off. Comparing the request widths against the programmed gap separates a correct latch-and-clear detector from one that mixes up direction, width or masking.

// File: rtl/synth_pkg.sv
package synth_pkg;

  // Detector request state, decoded from the two edge latches.
  typedef enum logic [1:0] {
    PUMP_IDLE = 2'b00,
    PUMP_SRC  = 2'b10,
    PUMP_SNK  = 2'b01,
    PUMP_BOTH = 2'b11
  } pump_state_e;

  // Number of counter states for which a divided wave stays high.
  function automatic int unsigned high_span(input int unsigned r);
    return (r + 1) / 2;
  endfunction

  // Width needed to count 0..r-1.
  function automatic int unsigned count_bits(input int unsigned r);
    return (r < 2) ? 1 : $clog2(r);
  endfunction

endpackage

// File: rtl/synth_fixed_div.sv
module synth_fixed_div
  import synth_pkg::*;
#(
  parameter int unsigned RATIO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic wave,
  output logic fall,
  output logic wrap
);

  localparam int unsigned CW     = count_bits(RATIO);
  localparam int unsigned HI     = high_span(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
  localparam logic [CW-1:0] DROP = CW'(HI - 1);

  logic [CW-1:0] cnt_q;
  logic          wave_q;

  assign wrap = tick && (cnt_q == LAST);
  assign fall = tick && (cnt_q == DROP);
  assign wave = wave_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q <= 1'b1;
    end else if (wrap) begin
      wave_q <= 1'b1;
    end else if (fall) begin
      wave_q <= 1'b0;
    end
  end

endmodule

// File: rtl/synth_prog_div.sv
module synth_prog_div #(
  parameter int unsigned N_BITS = 15,
  parameter int unsigned N_MIN  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [N_BITS-1:0] ratio_in,
  output logic              wave,
  output logic              fall,
  output logic              wrap,
  output logic [N_BITS-1:0] active_ratio
);

  localparam logic [N_BITS-1:0] FLOOR = N_BITS'(N_MIN);

  function automatic logic [N_BITS-1:0] floor_ratio(input logic [N_BITS-1:0] n);
    return (n < FLOOR) ? FLOOR : n;
  endfunction

  logic [N_BITS-1:0] cnt_q;
  logic [N_BITS-1:0] cur_q;
  logic              wave_q;
  logic [N_BITS:0]   half_span;
  logic [N_BITS-1:0] drop_at;
  logic [N_BITS-1:0] last_at;

  always_comb begin
    half_span = ({1'b0, cur_q} + (N_BITS+1)'(1)) >> 1;
    drop_at   = N_BITS'(half_span - (N_BITS+1)'(1));
    last_at   = cur_q - N_BITS'(1);
  end

  assign wrap         = tick && (cnt_q == last_at);
  assign fall         = tick && (cnt_q == drop_at);
  assign wave         = wave_q;
  assign active_ratio = cur_q;

  // Count and ratio update: the new ratio is taken only on wrap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cur_q <= FLOOR;
    end else if (wrap) begin
      cnt_q <= '0;
      cur_q <= floor_ratio(ratio_in);
    end else if (tick) begin
      cnt_q <= cnt_q + N_BITS'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q <= 1'b1;
    end else if (wrap) begin
      wave_q <= 1'b1;
    end else if (fall) begin
      wave_q <= 1'b0;
    end
  end

endmodule

// File: rtl/synth_phase_det.sv
module synth_phase_det (
  input  logic clk,
  input  logic rst_n,
  input  logic div_fall,
  input  logic ref_fall,
  output logic up_q,
  output logic dn_q
);

  logic both_set;

  assign both_set = up_q && dn_q;

  // Each edge sets its latch; once both are set they clear together.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (both_set) begin
      up_q <= div_fall;
      dn_q <= ref_fall;
    end else begin
      up_q <= up_q || div_fall;
      dn_q <= dn_q || ref_fall;
    end
  end

endmodule

// File: rtl/synth_pfd_core.sv
module synth_pfd_core
  import synth_pkg::*;
#(
  parameter int unsigned N_BITS   = 15,
  parameter int unsigned N_MIN    = 256,
  parameter int unsigned PRESCALE = 8,
  parameter int unsigned REF_DIV  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vco_tick,
  input  logic              xtal_tick,
  input  logic [N_BITS-1:0] ratio,
  input  logic              cp_off,
  input  logic              test_en,
  input  logic              hi_cur,
  input  logic              amp_off,
  input  logic [1:0]        port_ctl,
  output logic              pump_up,
  output logic              pump_dn,
  output logic              pump_hiz,
  output logic              cur_hi,
  output logic              amp_en,
  output logic              port6,
  output logic              port7
);

  // Named internal events, visible to the bound checker.
  logic              presc_wrap;
  logic              presc_fall;
  logic              presc_wave;
  logic              ref_wave;
  logic              ref_fall;
  logic              ref_wrap;
  logic              div_wave;
  logic              div_fall;
  logic              prog_wrap;
  logic [N_BITS-1:0] cur_ratio;
  logic              up_latch;
  logic              dn_latch;
  pump_state_e       pump_state;

  synth_fixed_div #(.RATIO(PRESCALE)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (vco_tick),
    .wave  (presc_wave),
    .fall  (presc_fall),
    .wrap  (presc_wrap)
  );

  synth_prog_div #(.N_BITS(N_BITS), .N_MIN(N_MIN)) u_prog (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (presc_wrap),
    .ratio_in     (ratio),
    .wave         (div_wave),
    .fall         (div_fall),
    .wrap         (prog_wrap),
    .active_ratio (cur_ratio)
  );

  synth_fixed_div #(.RATIO(REF_DIV)) u_ref (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (xtal_tick),
    .wave  (ref_wave),
    .fall  (ref_fall),
    .wrap  (ref_wrap)
  );

  synth_phase_det u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_fall (div_fall),
    .ref_fall (ref_fall),
    .up_q     (up_latch),
    .dn_q     (dn_latch)
  );

  assign pump_state = pump_state_e'({up_latch, dn_latch});

  always_comb begin
    pump_up  = 1'b0;
    pump_dn  = 1'b0;
    if (!cp_off) begin
      unique case (pump_state)
        PUMP_SRC: pump_up = 1'b1;
        PUMP_SNK: pump_dn = 1'b1;
        default:  ;
      endcase
    end
    pump_hiz = !(pump_up || pump_dn);
  end

  assign cur_hi = hi_cur;
  assign amp_en = !amp_off;
  assign port6  = test_en ? ref_wave : port_ctl[0];
  assign port7  = test_en ? div_wave : port_ctl[1];

endmodule

// File: rtl/synth_pfd_core_chk.sv
module synth_pfd_core_chk #(
  parameter int unsigned N_BITS = 15,
  parameter int unsigned N_MIN  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cp_off,
  input logic              pump_up,
  input logic              pump_dn,
  input logic              pump_hiz,
  input logic              presc_wrap,
  input logic              presc_fall,
  input logic              presc_wave,
  input logic              ref_wrap,
  input logic              ref_fall,
  input logic              ref_wave,
  input logic              div_fall,
  input logic              prog_wrap,
  input logic [N_BITS-1:0] cur_ratio,
  input logic              up_latch,
  input logic              dn_latch
);

  assert_pump_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

  assert_latch_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (up_latch && dn_latch) |=> !(up_latch && dn_latch));

  assert_ratio_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ratio >= N_BITS'(N_MIN));

  assert_load_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_wrap |=> $stable(cur_ratio));

  assert_up_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_fall |=> up_latch);

  assert_dn_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fall |=> dn_latch);

  assert_forced_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cp_off |-> (pump_hiz && !pump_up && !pump_dn));

  assert_ref_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_wrap |=> ref_wave);

  assert_ref_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fall |=> !ref_wave);

  assert_presc_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
    presc_wrap |=> (presc_wave && !presc_fall));

endmodule

bind synth_pfd_core synth_pfd_core_chk #(.N_BITS(N_BITS), .N_MIN(N_MIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cp_off     (cp_off),
  .pump_up    (pump_up),
  .pump_dn    (pump_dn),
  .pump_hiz   (pump_hiz),
  .presc_wrap (presc_wrap),
  .presc_fall (presc_fall),
  .presc_wave (presc_wave),
  .ref_wrap   (ref_wrap),
  .ref_fall   (ref_fall),
  .ref_wave   (ref_wave),
  .div_fall   (div_fall),
  .prog_wrap  (prog_wrap),
  .cur_ratio  (cur_ratio),
  .up_latch   (up_latch),
  .dn_latch   (dn_latch)
);

// File: tb/synth_pfd_core_test.sv
module synth_pfd_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vco_tick = 1'b0;
  logic        xtal_tick = 1'b0;
  logic [14:0] ratio = 15'd301;
  logic        cp_off = 1'b0;
  logic        test_en = 1'b0;
  logic        hi_cur = 1'b0;
  logic        amp_off = 1'b0;
  logic [1:0]  port_ctl = 2'b10;
  logic        pump_up, pump_dn, pump_hiz, cur_hi, amp_en, port6, port7;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  synth_pfd_core uut (
    .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .xtal_tick(xtal_tick),
    .ratio(ratio), .cp_off(cp_off), .test_en(test_en), .hi_cur(hi_cur),
    .amp_off(amp_off), .port_ctl(port_ctl), .pump_up(pump_up),
    .pump_dn(pump_dn), .pump_hiz(pump_hiz), .cur_hi(cur_hi),
    .amp_en(amp_en), .port6(port6), .port7(port7)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard for the divided input wave on port7.
  int exp_per[$];
  int exp_high[$];
  bit mon_on = 1'b0;
  bit armed = 1'b0;
  int rise_count = 0;
  int since_rise = 0;
  int high_len = 0;
  logic prev7 = 1'b1;

  always @(negedge clk) begin
    if (mon_on) begin
      since_rise++;
      if (prev7 && !port7) high_len = since_rise;
      if (!prev7 && port7) begin
        if (armed) begin
          if (exp_per.size() == 0) begin
            chk("R3 unexpected period", since_rise, -1);
          end else begin
            chk("R1/R3 period", since_rise, exp_per.pop_front());
            chk("R2 high span", high_len, exp_high.pop_front());
          end
        end
        armed = 1'b1;
        since_rise = 0;
        rise_count++;
      end
    end
    prev7 = port7;
  end

  // Reference wave monitor on port6.
  int ref_checks = 0;
  int ref_since = 0;
  int ref_high = 0;
  bit ref_armed = 1'b0;
  logic prev6 = 1'b1;

  always @(negedge clk) begin
    if (mon_on) begin
      ref_since++;
      if (prev6 && !port6) ref_high = ref_since;
      if (!prev6 && port6) begin
        if (ref_armed && ref_checks < 3) begin
          chk("R5 reference period", ref_since, 512);
          chk("R5 reference high", ref_high, 256);
          ref_checks++;
        end
        ref_armed = 1'b1;
        ref_since = 0;
      end
    end
    prev6 = port6;
  end

  task automatic push_ratio(input int n, input int count);
    int eff;
    eff = (n < 256) ? 256 : n;
    for (int i = 0; i < count; i++) begin
      exp_per.push_back(8 * eff);
      exp_high.push_back(8 * ((eff + 1) / 2));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    vco_tick = 1'b0;
    xtal_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Bring both dividers to one tick before their falling edges
  // (active ratio 256 after reset: 1023 input ticks, 255 crystal ticks).
  task automatic prime();
    for (int i = 0; i < 1023; i++) begin
      vco_tick = 1'b1;
      xtal_tick = (i < 255);
      @(negedge clk);
    end
    vco_tick = 1'b0;
    xtal_tick = 1'b0;
  endtask

  task automatic run_pfd(input bit div_first, input int gap, input bit off,
                         input string req);
    int up_n, dn_n, hiz_lo, both;
    up_n = 0; dn_n = 0; hiz_lo = 0; both = 0;
    cp_off = off;
    do_reset();
    prime();
    vco_tick = (gap == 0) || div_first;
    xtal_tick = (gap == 0) || !div_first;
    for (int k = 1; k <= gap + 6; k++) begin
      @(negedge clk);
      if (pump_up) up_n++;
      if (pump_dn) dn_n++;
      if (!pump_hiz) hiz_lo++;
      if (pump_up && pump_dn) both++;
      vco_tick = (k == gap) && !div_first;
      xtal_tick = (k == gap) && div_first;
    end
    vco_tick = 1'b0;
    xtal_tick = 1'b0;
    chk({req, " up cycles"}, up_n, (div_first && gap > 0 && !off) ? gap : 0);
    chk({req, " down cycles"}, dn_n, (!div_first && gap > 0 && !off) ? gap : 0);
    chk({req, " R9 hiz low cycles"}, hiz_lo, (gap > 0 && !off) ? gap : 0);
    chk({req, " R12 both"}, both, 0);
    cp_off = 1'b0;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    // R13 reset state, R10 software-driven pins
    chk("R13 pump_up", pump_up, 0);
    chk("R13 pump_dn", pump_dn, 0);
    chk("R13 pump_hiz", pump_hiz, 1);
    chk("R10 port6 sw", port6, 0);
    chk("R10 port7 sw", port7, 1);
    port_ctl = 2'b01;
    @(negedge clk);
    chk("R10 port6 sw", port6, 1);
    chk("R10 port7 sw", port7, 0);
    test_en = 1'b1;
    @(negedge clk);
    chk("R13 port6 wave high", port6, 1);
    chk("R13 port7 wave high", port7, 1);
    // R11 level controls
    hi_cur = 1'b1; amp_off = 1'b1;
    @(negedge clk);
    chk("R11 cur_hi", cur_hi, 1);
    chk("R11 amp_en", amp_en, 0);
    hi_cur = 1'b0; amp_off = 1'b0;
    @(negedge clk);
    chk("R11 cur_hi", cur_hi, 0);
    chk("R11 amp_en", amp_en, 1);

    // Divider scoreboard: R1, R2, R3, R4, R5
    port_ctl = 2'b00;
    ratio = 15'd301;
    do_reset();
    vco_tick = 1'b1;
    xtal_tick = 1'b1;
    mon_on = 1'b1;
    push_ratio(301, 3);
    wait (rise_count == 3);
    repeat (50) @(negedge clk);
    ratio = 15'd100;                 // R4 floor, R3 load at next wrap
    push_ratio(100, 2);
    wait (rise_count == 5);
    repeat (50) @(negedge clk);
    ratio = 15'd520;
    push_ratio(520, 2);
    wait (rise_count == 8);
    @(negedge clk);
    mon_on = 1'b0;
    chk("R3 scoreboard drained", exp_per.size(), 0);
    vco_tick = 1'b0;
    xtal_tick = 1'b0;

    // Detector orderings
    run_pfd(1'b1, 5, 1'b0, "R6 input first");
    run_pfd(1'b0, 7, 1'b0, "R7 reference first");
    run_pfd(1'b1, 0, 1'b0, "R8 coincident");
    run_pfd(1'b1, 6, 1'b1, "R9 forced off");
    run_pfd(1'b0, 1, 1'b0, "R7 one-cycle gap");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule